// File: doc/BRIEF.md
# Reciprocal Frequency Counter with Edge-Aligned Window

This block measures the frequency of a digital input that has already been squared up. A single fast reference clock runs all of its logic. The measured signal enters through a flop synchronizer, and its rising edges are detected in the reference domain. An external controller raises and lowers a gate request, which is synchronous to the reference clock. The block does not open or close its counting window on the gate itself. The window opens on the first measured rising edge after the request goes high. It closes on the first measured rising edge after the request goes low. Because of this, the window always spans a whole number of input periods.

Two counters run over the same window. One counts reference cycles and the other counts measured rising edges. When the window closes, both counts and an overflow flag are latched into output registers. A one-cycle done pulse is then raised together with a sticky valid flag. The controller computes the frequency as sig_count × F_ref / ref_count. The quantisation error is one reference cycle whatever the input frequency, so the relative accuracy depends only on the gate length.

Top module: `recip_freq_counter`

## Requirements
- R1: While reset is held and after it is released, `done`, `valid` and `overflow` read 0 and both counts read 0.
- R2: A new measurement starts when `gate_req` is high while the block is idle, and both counters clear at that point. Counting begins on the first detected rising edge of `sig_in` after that start. A completed measurement gives a nonzero `sig_count`, and `sig_count` × period stays within one input period (plus the synchronizer latency) of the gate length.
- R3: After `gate_req` falls, counting stops on the next detected rising edge of `sig_in`. `sig_count` equals the number N of whole input periods in the window. `ref_count` is within ±1 of N × P, where P is the input period in reference cycles.
- R4: `done` is high for exactly one cycle per completed measurement. `valid` is set together with `done` and stays set until reset.
- R5: The output counts and `overflow` keep their previous values while a new measurement is running, and change only in the cycle `done` rises.
- R6: If `gate_req` falls before any rising edge of `sig_in` is seen, the measurement completes at once with `done` set and both counts 0.
- R7: A counter that reaches all ones stays at all ones instead of wrapping, and `overflow` is reported as 1 for that measurement.
- R8: Every rising edge is counted once. The fastest input, a period of 2 reference cycles, is counted with no lost or duplicated edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| gate_req | input | 1 | Gate request from the controller, synchronous to clk |
| sig_in | input | 1 | Conditioned measured signal, asynchronous |
| done | output | 1 | One-cycle pulse when a result is latched |
| valid | output | 1 | At least one result has been latched since reset |
| ref_count | output | CNT_W | Reference cycles counted in the window |
| sig_count | output | CNT_W | Measured rising edges counted in the window |
| overflow | output | 1 | One of the two counters saturated during the latched measurement |

## Verification
The assertions assume that `gate_req` changes only on reference-clock edges. They also assume that each high and low phase of `sig_in` lasts at least one reference cycle, so that detected edges can never fall in adjacent cycles. The stimulus drives both inputs on the falling clock edge. It builds `sig_in` as a square wave with an integer period of two or more reference cycles. A small-width second instance is used to reach saturation within a short run.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
  typedef enum logic [1:0] {
    WIN_IDLE  = 2'd0,
    WIN_ARM   = 2'd1,
    WIN_OPEN  = 2'd2,
    WIN_DRAIN = 2'd3
  } win_state_t;
endpackage

// File: rtl/rfc_sync_edge.sv
module rfc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  localparam int TAPS = STAGES + 1;

  logic [TAPS-1:0] tap_q;

  genvar gi;
  generate
    for (gi = 0; gi < TAPS; gi++) begin : g_tap
      logic tap_d;
      if (gi == 0) begin : g_first
        assign tap_d = din;
      end else begin : g_rest
        assign tap_d = tap_q[gi-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tap_q[gi] <= 1'b0;
        else        tap_q[gi] <= tap_d;
      end
    end
  endgenerate

  assign rise = tap_q[STAGES-1] & ~tap_q[STAGES];

  // R8
  rise_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/rfc_window_ctl.sv
module rfc_window_ctl
  import rfc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic gate,
  input  logic rise,
  output logic clr,
  output logic ref_inc,
  output logic sig_inc,
  output logic close
);
  win_state_t st_q, st_d;

  always_comb begin
    st_d  = st_q;
    clr   = 1'b0;
    close = 1'b0;
    unique case (st_q)
      WIN_IDLE: begin
        if (gate) begin
          clr  = 1'b1;
          st_d = WIN_ARM;
        end
      end
      WIN_ARM: begin
        if (!gate) begin
          close = 1'b1;
          st_d  = WIN_IDLE;
        end else if (rise) begin
          st_d = WIN_OPEN;
        end
      end
      WIN_OPEN: begin
        if (!gate) st_d = WIN_DRAIN;
      end
      WIN_DRAIN: begin
        if (rise) begin
          close = 1'b1;
          st_d  = WIN_IDLE;
        end
      end
      default: st_d = WIN_IDLE;
    endcase
  end

  assign ref_inc = (st_q == WIN_OPEN) || (st_q == WIN_DRAIN);
  assign sig_inc = ref_inc && rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= WIN_IDLE;
    else        st_q <= st_d;
  end

  // R2
  open_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == WIN_ARM && gate && rise) |=> ref_inc);
  // R3
  stop_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == WIN_DRAIN && rise) |=> !ref_inc);
endmodule

// File: rtl/rfc_sat_counter.sv
module rfc_sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count,
  output logic         sat
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] count_d;
  logic         sat_d;
  logic         cnt_en;

  always_comb begin
    cnt_en  = clr || inc;
    count_d = count;
    sat_d   = sat;
    if (clr) begin
      count_d = '0;
      sat_d   = 1'b0;
    end else if (inc) begin
      if (count == TOP) sat_d = 1'b1;
      else              count_d = count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      sat   <= 1'b0;
    end else if (cnt_en) begin
      count <= count_d;
      sat   <= sat_d;
    end
  end

  // R7
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && inc && count == TOP) |=> (count == TOP && sat));
  // R7
  sat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sat && !clr) |=> sat);
endmodule

// File: rtl/recip_freq_counter.sv
module recip_freq_counter #(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_req,
  input  logic             sig_in,
  output logic             done,
  output logic             valid,
  output logic [CNT_W-1:0] ref_count,
  output logic [CNT_W-1:0] sig_count,
  output logic             overflow
);
  logic [1:0]       rst_pipe_q;
  logic             rst_i_n;
  logic             rise, clr, ref_inc, sig_inc, close;
  logic             close_q;
  logic [CNT_W-1:0] ref_live, sig_live;
  logic             ref_sat, sig_sat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_i_n = rst_pipe_q[1];

  rfc_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_i_n), .din(sig_in), .rise(rise)
  );

  rfc_window_ctl u_win (
    .clk(clk), .rst_n(rst_i_n), .gate(gate_req), .rise(rise),
    .clr(clr), .ref_inc(ref_inc), .sig_inc(sig_inc), .close(close)
  );

  rfc_sat_counter #(.W(CNT_W)) u_ref_cnt (
    .clk(clk), .rst_n(rst_i_n), .clr(clr), .inc(ref_inc),
    .count(ref_live), .sat(ref_sat)
  );

  rfc_sat_counter #(.W(CNT_W)) u_sig_cnt (
    .clk(clk), .rst_n(rst_i_n), .clr(clr), .inc(sig_inc),
    .count(sig_live), .sat(sig_sat)
  );

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      close_q <= 1'b0;
      done    <= 1'b0;
    end else begin
      close_q <= close;
      done    <= close_q;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      valid     <= 1'b0;
      ref_count <= '0;
      sig_count <= '0;
      overflow  <= 1'b0;
    end else if (close_q) begin
      valid     <= 1'b1;
      ref_count <= ref_live;
      sig_count <= sig_live;
      overflow  <= ref_sat | sig_sat;
    end
  end

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R4
  done_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> valid);
  // R4
  valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> valid);
  // R5
  hold_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> ($stable(ref_count) && $stable(sig_count) && $stable(overflow)) || done);
  // R6
  empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && sig_count == '0) |-> ref_count == '0);
endmodule

// File: tb/recip_freq_counter_test.sv
module recip_freq_counter_test;
  localparam int NV = 6;
  localparam int VPER  [NV] = '{2, 3, 7, 16, 50, 5};
  localparam int VGATE [NV] = '{200, 301, 500, 1000, 2000, 97};
  localparam int SW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gate_req = 1'b0;
  logic sig_in = 1'b0;
  logic sig_run = 1'b0;
  int   cur_per = 4;
  int   ph = 0;

  logic        done, valid, overflow;
  logic [31:0] ref_count, sig_count;
  logic        s_done, s_valid, s_ovf;
  logic [SW-1:0] s_ref, s_sig;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  recip_freq_counter uut (
    .clk(clk), .rst_n(rst_n), .gate_req(gate_req), .sig_in(sig_in),
    .done(done), .valid(valid), .ref_count(ref_count),
    .sig_count(sig_count), .overflow(overflow)
  );

  recip_freq_counter #(.CNT_W(SW)) uut_small (
    .clk(clk), .rst_n(rst_n), .gate_req(gate_req), .sig_in(sig_in),
    .done(s_done), .valid(s_valid), .ref_count(s_ref),
    .sig_count(s_sig), .overflow(s_ovf)
  );

  always @(negedge clk) begin
    if (!sig_run) begin
      sig_in <= 1'b0;
      ph     <= 0;
    end else begin
      sig_in <= (ph < cur_per / 2);
      ph     <= (ph + 1 >= cur_per) ? 0 : ph + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 6000 && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
  endtask

  task automatic measure(input int per, input int glen, input string tag);
    bit seen;
    longint n, r, d;
    cur_per = per;
    sig_run = 1'b1;
    repeat (8) @(negedge clk);
    gate_req = 1'b1;
    repeat (glen) @(negedge clk);
    gate_req = 1'b0;
    wait_done(seen);
    check(seen, {tag, " R3 done seen"}, seen, 1);
    n = sig_count;
    r = ref_count;
    d = r - n * per;
    check(n > 0, {tag, " R2 nonzero edges"}, n, 1);
    check(d <= 1 && d >= -1, {tag, " R3 ref vs N*P"}, r, n * per);
    d = n * per - glen;
    check(d <= per + 4 && d >= -(per + 4), {tag, " R2 window vs gate"}, n * per, glen);
    check(valid == 1'b1 && overflow == 1'b0, {tag, " R4 valid no ovf"}, {valid, overflow}, 2);
    @(negedge clk);
    check(done == 1'b0, {tag, " R4 done one cycle"}, done, 0);
  endtask

  initial begin
    bit seen;
    longint held_r, held_s;
    repeat (3) @(negedge clk);
    check(done == 0 && valid == 0 && overflow == 0, "R1 in reset flags", {done, valid, overflow}, 0);
    check(ref_count == 0 && sig_count == 0, "R1 in reset counts", ref_count + sig_count, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(done == 0 && valid == 0 && ref_count == 0 && sig_count == 0 && overflow == 0,
          "R1 after release", {done, valid, overflow}, 0);

    for (int v = 0; v < NV; v++) begin
      measure(VPER[v], VGATE[v], (v == 0) ? "vec R8" : "vec");
    end

    // R8: period 2 with exact edge count bound
    measure(2, 400, "R8 fastest");
    check(sig_count >= 199 && sig_count <= 202, "R8 edge count", sig_count, 200);

    // R5: results held during a new measurement
    held_r = ref_count;
    held_s = sig_count;
    cur_per = 9;
    repeat (4) @(negedge clk);
    gate_req = 1'b1;
    repeat (300) @(negedge clk);
    check(ref_count == held_r && sig_count == held_s, "R5 hold during gate", ref_count, held_r);
    gate_req = 1'b0;
    repeat (3) @(negedge clk);
    check(ref_count == held_r, "R5 hold while draining", ref_count, held_r);
    wait_done(seen);
    check(seen && sig_count > 0 && ref_count == sig_count * 9, "R5 new result", ref_count, sig_count * 9);

    // R6: empty measurement
    sig_run = 1'b0;
    repeat (10) @(negedge clk);
    gate_req = 1'b1;
    repeat (20) @(negedge clk);
    gate_req = 1'b0;
    wait_done(seen);
    check(seen, "R6 empty done", seen, 1);
    check(ref_count == 0 && sig_count == 0, "R6 empty counts", ref_count + sig_count, 0);
    check(valid == 1'b1, "R4 valid sticky", valid, 1);

    // R7: saturation on small instance
    measure(4, 600, "R7 run");
    check(s_ovf == 1'b1, "R7 small overflow", s_ovf, 1);
    check(s_ref == {SW{1'b1}}, "R7 small saturates", s_ref, 255);
    check(overflow == 1'b0 && ref_count > 255, "R7 wide no overflow", overflow, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule